// File: doc/BRIEF.md
# Byte Arithmetic and Logic Unit with Condition Flags

This block is a purely combinational arithmetic and logic unit for a small processor datapath. It takes two operands and a 4-bit operation code. It returns a result word, a hint that tells the register file whether the destination should be written, and four condition flags: zero, negative, carry and overflow. The same inputs always give the same outputs; nothing is stored.

The unit supports these operations: addition, subtraction, the three bitwise operations, single-bit left and right shifts, the low half of an unsigned product, and unsigned division. Compare works like subtraction but raises no write hint. Codes outside the defined set pass the first operand through, and the surrounding sequencer handles them.

The operand width is a parameter called `WIDTH`. It defaults to 8, and every sign, carry and range rule below is stated in terms of it. Inside the block, a decoder turns the code into a small bundle of strobes, and the datapath acts on those strobes.

Top module: `byte_alu`

## Requirements
- R1: Code 0 (add) returns (a + b) mod 2^WIDTH. Carry is the carry-out of the top bit. Overflow is 1 exactly when the result's top bit differs from the top bits of both a and b.
- R2: Code 1 (subtract) returns a + ~b + 1 mod 2^WIDTH. Carry is the final carry-out, so it is 1 when a >= b unsigned (no borrow). Overflow is 1 exactly when the top bits of a and b differ and the result's top bit differs from a's.
- R3: Codes 2, 3 and 4 return a AND b, a OR b and a XOR b, bit by bit, with carry and overflow both 0.
- R4: Code 5 shifts a left by one and fills bit 0 with 0. Carry takes the old top bit of a, and overflow is 0.
- R5: Code 6 shifts a right by one, logically, and fills the top bit with 0. Carry takes the old bit 0 of a, and overflow is 0.
- R6: Code 7 returns the low WIDTH bits of the unsigned product a*b. Carry is 1 exactly when the full product exceeds 2^WIDTH - 1, and overflow is 0.
- R7: Code 8 returns the unsigned quotient floor(a/b) with carry and overflow 0 when b is non-zero. When b is zero it returns 0 with carry = 1 and overflow = 1.
- R8: For every code, zero is 1 exactly when the result is all zeros, and negative equals the result's top bit (bit WIDTH-1).
- R9: Code 9 (compare) returns the same result and flags as code 1 for the same operands, and drives the write hint to 0.
- R10: For codes 0 through 8 the write hint is 1.
- R11: Codes 10 through 15 return a unchanged, with carry and overflow 0 and the write hint 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand; the one that is shifted, and the dividend |
| opB | input | WIDTH | Second operand; the divisor |
| opCode | input | 4 | Operation select, codes 0 to 15 |
| result | output | WIDTH | Operation result |
| writeEn | output | 1 | Hint that the destination register should be written |
| flagZ | output | 1 | Result is zero |
| flagN | output | 1 | Top bit of the result |
| flagC | output | 1 | Carry, no-borrow, shifted-out bit or product-overflow |
| flagV | output | 1 | Signed overflow, or divide by zero |

## Verification
The bench builds two copies of the block. The first uses WIDTH = 4, and there every combination of operand pair and operation code is applied. This covers each carry and overflow boundary, every shift-out bit, every product that goes past the top, and every divisor including zero. The second uses the default WIDTH = 8 and applies a cross product of twelve corner values under all sixteen codes. This exercises the sign boundary at 0x7F/0x80, the all-ones and alternating patterns, and full-width divide by zero, all at the production width.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  localparam int OP_BITS = 4;

  typedef enum logic [OP_BITS-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_SHL = 4'd5,
    OP_SHR = 4'd6,
    OP_MUL = 4'd7,
    OP_DIV = 4'd8,
    OP_CMP = 4'd9
  } aluOp_e;

  typedef enum logic [3:0] {
    RSEL_ADD,
    RSEL_AND,
    RSEL_OR,
    RSEL_XOR,
    RSEL_SHL,
    RSEL_SHR,
    RSEL_MUL,
    RSEL_DIV,
    RSEL_PASS
  } resSel_e;

  typedef struct packed {
    resSel_e resSel;
    logic    invertB;
    logic    writeBack;
  } aluStrobes_t;

endpackage

// File: rtl/byte_alu_ctrl.sv
module byte_alu_ctrl
  import byte_alu_pkg::*;
(
  input  logic [OP_BITS-1:0] opCode,
  output aluStrobes_t        strobes
);

  always_comb begin
    strobes.resSel    = RSEL_PASS;
    strobes.invertB   = 1'b0;
    strobes.writeBack = 1'b0;
    case (opCode)
      OP_ADD: begin strobes.resSel = RSEL_ADD; strobes.writeBack = 1'b1; end
      OP_SUB: begin strobes.resSel = RSEL_ADD; strobes.invertB = 1'b1; strobes.writeBack = 1'b1; end
      OP_AND: begin strobes.resSel = RSEL_AND; strobes.writeBack = 1'b1; end
      OP_OR:  begin strobes.resSel = RSEL_OR;  strobes.writeBack = 1'b1; end
      OP_XOR: begin strobes.resSel = RSEL_XOR; strobes.writeBack = 1'b1; end
      OP_SHL: begin strobes.resSel = RSEL_SHL; strobes.writeBack = 1'b1; end
      OP_SHR: begin strobes.resSel = RSEL_SHR; strobes.writeBack = 1'b1; end
      OP_MUL: begin strobes.resSel = RSEL_MUL; strobes.writeBack = 1'b1; end
      OP_DIV: begin strobes.resSel = RSEL_DIV; strobes.writeBack = 1'b1; end
      OP_CMP: begin strobes.resSel = RSEL_ADD; strobes.invertB = 1'b1; end
      default: ;
    endcase
  end

endmodule

// File: rtl/byte_alu_dp.sv
module byte_alu_dp
  import byte_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             flagZ,
  output logic             flagN,
  output logic             flagC,
  output logic             flagV
);

  localparam int MSB     = WIDTH - 1;
  localparam int PROD_W  = 2 * WIDTH;

  logic [WIDTH-1:0]  bEff;
  logic [WIDTH:0]    carryChain;
  logic [WIDTH-1:0]  sumBits;
  logic              addOverflow;
  logic [PROD_W-1:0] product;
  logic              productHigh;
  logic              divByZero;
  logic [WIDTH-1:0]  quotient;

  assign bEff          = strobes.invertB ? ~opB : opB;
  assign carryChain[0] = strobes.invertB;

  // Ripple chain of full adders shared by add, subtract and compare.
  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    logic halfSum;
    assign halfSum           = opA[i] ^ bEff[i];
    assign sumBits[i]        = halfSum ^ carryChain[i];
    assign carryChain[i + 1] = (opA[i] & bEff[i]) | (halfSum & carryChain[i]);
  end

  // Sign disagreement of the sum against both adder inputs; with the
  // inverted operand this reduces to the subtract overflow rule.
  assign addOverflow = (opA[MSB] ^ sumBits[MSB]) & (bEff[MSB] ^ sumBits[MSB]);

  assign product     = {{WIDTH{1'b0}}, opA} * {{WIDTH{1'b0}}, opB};
  assign productHigh = |product[PROD_W-1:WIDTH];

  assign divByZero = (opB == '0);
  assign quotient  = divByZero ? '0 : (opA / opB);

  always_comb begin
    result = opA;
    flagC  = 1'b0;
    flagV  = 1'b0;
    case (strobes.resSel)
      RSEL_ADD: begin
        result = sumBits;
        flagC  = carryChain[WIDTH];
        flagV  = addOverflow;
      end
      RSEL_AND: result = opA & opB;
      RSEL_OR:  result = opA | opB;
      RSEL_XOR: result = opA ^ opB;
      RSEL_SHL: begin
        result = {opA[MSB-1:0], 1'b0};
        flagC  = opA[MSB];
      end
      RSEL_SHR: begin
        result = {1'b0, opA[MSB:1]};
        flagC  = opA[0];
      end
      RSEL_MUL: begin
        result = product[WIDTH-1:0];
        flagC  = productHigh;
      end
      RSEL_DIV: begin
        result = quotient;
        flagC  = divByZero;
        flagV  = divByZero;
      end
      default: result = opA;
    endcase
  end

  assign flagZ = (result == '0);
  assign flagN = result[MSB];

endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic [OP_BITS-1:0] opCode,
  output logic [WIDTH-1:0]   result,
  output logic               writeEn,
  output logic               flagZ,
  output logic               flagN,
  output logic               flagC,
  output logic               flagV
);

  aluStrobes_t strobes;

  byte_alu_ctrl u_ctrl (
    .opCode  (opCode),
    .strobes (strobes)
  );

  byte_alu_dp #(.WIDTH(WIDTH)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result),
    .flagZ   (flagZ),
    .flagN   (flagN),
    .flagC   (flagC),
    .flagV   (flagV)
  );

  assign writeEn = strobes.writeBack;

endmodule

// File: rtl/byte_alu_checker.sv
module byte_alu_checker #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [3:0]       opCode,
  input logic [WIDTH-1:0] result,
  input logic             writeEn,
  input logic             flagZ,
  input logic             flagN,
  input logic             flagC,
  input logic             flagV
);

  always_comb begin
    if (!$isunknown({opA, opB, opCode, result, writeEn, flagZ, flagN, flagC, flagV})) begin
      if (opCode == 4'd9)
        a_r9_cmp_no_write: assert (!writeEn);
      if (opCode <= 4'd8)
        a_r10_write_hint: assert (writeEn);
      if (opCode == 4'd8 && opB == '0)
        a_r7_div_zero: assert (result == '0 && flagC && flagV);
      if (opCode >= 4'd2 && opCode <= 4'd4)
        a_r3_logic_clear: assert (!flagC && !flagV);
      if (opCode == 4'd5)
        a_r4_shl_carry: assert (flagC == opA[WIDTH-1] && !result[0] && !flagV);
      if (opCode == 4'd6)
        a_r5_shr_carry: assert (flagC == opA[0] && !result[WIDTH-1] && !flagV);
      if (opCode >= 4'd10)
        a_r11_pass: assert (result == opA && !flagC && !flagV && !writeEn);
      a_r8_flag_excl: assert (!(flagZ && flagN));
    end
  end

endmodule

bind byte_alu byte_alu_checker #(.WIDTH(WIDTH)) u_checker (
  .opA     (opA),
  .opB     (opB),
  .opCode  (opCode),
  .result  (result),
  .writeEn (writeEn),
  .flagZ   (flagZ),
  .flagN   (flagN),
  .flagC   (flagC),
  .flagV   (flagV)
);

// File: tb/byte_alu_bench.sv
module byte_alu_bench;

  localparam int WIDE   = 8;
  localparam int NARROW = 4;
  localparam int WATCHDOG_CYCLES = 200000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst;
  int   vectors = 0;
  int   fails   = 0;
  bit   done    = 1'b0;

  logic [WIDE-1:0]   aW, bW, resW;
  logic [3:0]        opW;
  logic              weW, zW, nW, cW, vW;
  logic [NARROW-1:0] aN, bN, resN;
  logic [3:0]        opN;
  logic              weN, zN, nN, cN, vN;

  byte_alu #(.WIDTH(WIDE)) u_byte_alu (
    .opA(aW), .opB(bW), .opCode(opW), .result(resW), .writeEn(weW),
    .flagZ(zW), .flagN(nW), .flagC(cW), .flagV(vW)
  );

  byte_alu #(.WIDTH(NARROW)) u_byte_alu_narrow (
    .opA(aN), .opB(bN), .opCode(opN), .result(resN), .writeEn(weN),
    .flagZ(zN), .flagN(nN), .flagC(cN), .flagV(vN)
  );

  // Packed as {writeEn, Z, N, C, V, result[15:0]}.
  function automatic logic [20:0] model(int a, int b, int op, int w);
    int m   = (1 << w) - 1;
    int msb = 1 << (w - 1);
    int res = a;
    int s;
    logic c = 1'b0, v = 1'b0, wb;
    case (op)
      0: begin s = a + b; res = s & m; c = ((s >> w) & 1) != 0;
               v = (((a ^ res) & (b ^ res) & msb) != 0); end
      1, 9: begin s = a + ((~b) & m) + 1; res = s & m; c = ((s >> w) & 1) != 0;
               v = (((a ^ b) & (a ^ res) & msb) != 0); end
      2: res = a & b;
      3: res = a | b;
      4: res = a ^ b;
      5: begin c = (a & msb) != 0; res = (a << 1) & m; end
      6: begin c = (a & 1) != 0; res = a >> 1; end
      7: begin s = a * b; res = s & m; c = (s > m); end
      8: begin
        if (b == 0) begin res = 0; c = 1'b1; v = 1'b1; end
        else res = a / b;
      end
      default: res = a;
    endcase
    wb = (op <= 8);
    return {wb, (res == 0), ((res & msb) != 0), c, v, 16'(res)};
  endfunction

  function automatic string tagFor(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2, 3, 4: return "R3";
      5: return "R4";
      6: return "R5";
      7: return "R6";
      8: return "R7";
      9: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic compare(string inst, int a, int b, int op, logic [20:0] got, logic [20:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s,R8,R10 %s a=%0h b=%0h op=%0d actual=%h expected=%h",
               tagFor(op), inst, a, b, op, got, exp);
    end
  endtask

  task automatic applyWide(int a, int b, int op);
    @(negedge clk);
    aW = WIDE'(a); bW = WIDE'(b); opW = 4'(op);
    #2;
    compare("wide", a, b, op, {weW, zW, nW, cW, vW, 8'h00, resW}, model(a, b, op, WIDE));
  endtask

  task automatic applyNarrow(int a, int b, int op);
    @(negedge clk);
    aN = NARROW'(a); bN = NARROW'(b); opN = 4'(op);
    #2;
    compare("narrow", a, b, op, {weN, zN, nN, cN, vN, 12'h000, resN}, model(a, b, op, NARROW));
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  int corners [12] = '{8'h00, 8'h01, 8'h02, 8'h0F, 8'h10, 8'h55,
                       8'h7F, 8'h80, 8'h81, 8'hAA, 8'hFE, 8'hFF};

  initial begin
    rst = 1'b1;
    aW = '0; bW = '0; opW = '0;
    aN = '0; bN = '0; opN = '0;
    repeat (3) @(posedge clk);
    // Idle state: add of zeros gives zero result with Z and write hint (R8, R10).
    @(negedge clk);
    compare("wide-idle", 0, 0, 0, {weW, zW, nW, cW, vW, 8'h00, resW}, 21'h100000 | 21'h080000);
    rst = 1'b0;
    // Exhaustive narrow sweep: every operand pair under every code.
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          applyNarrow(a, b, op);
    // Wide corner cross product under every code.
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          applyWide(corners[i], corners[j], op);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=stalled expected=complete");
      summary();
      $finish;
    end
  end

endmodule